// File: doc/BRIEF.md
# Address-Masked GPIO Port

This block is an 8-pin general-purpose I/O port that sits behind a plain register strobe: an address, a write enable, a byte of write data, and a combinational byte of read data. A direction register chooses for each pin whether the block drives it. A data window covers the lower kilobyte of the address space. In that window, address bits [9:2] act as a per-pin lane mask. Software can therefore set or clear any subset of pins with a single write and does not need a read-modify-write sequence.

Toward the pads, the block drives an output-enable vector and an output-value vector, and it samples a pad-input vector through a two-flop synchroniser. A data write changes only those latches whose pins are both selected by the lane mask and currently configured as outputs. A value written to an input pin is dropped. Software sets the pin to output first and then writes its level.

Top module: `gpio_window_port`

## Requirements
- R1: After reset every pin is an input (pad_oe = 0), the output latch is 0 (pad_out = 0), and the direction register reads 0.
- R2: The direction register sits at address 0x400. A write there sets pad_oe to the written byte at the next clock edge (bit n = 1 makes pin n an output), and a read there returns the current direction byte.
- R3: A write anywhere in the data window (address[11:10] = 0, address[1:0] = 0) uses address bit n+2 as the lane of pin n. At the next edge, each pin whose lane bit is 1 and whose direction bit is 1 takes bit n of the write data on pad_out, and every other bit of pad_out holds its value. A write at 1 << (n+2) therefore touches pin n alone.
- R4: A data write to a pin configured as input leaves that pin's output latch unchanged. When the pin is later switched to output, pad_out shows the level the latch held before that write, until the level is written again.
- R5: A read in the data window returns 0 for every bit whose lane bit is 0. For a bit whose lane bit is 1, it returns the latched output value if the pin is an output, and the synchronised pad value if the pin is an input.
- R6: A change on pad_in shows up in data-window reads after two rising clock edges, and has not yet shown up after one.
- R7: Every address outside the data window other than 0x400 is unmapped, including non-word-aligned addresses and 0x404. Reads there return 0, and writes there change neither pad_oe nor pad_out.
- R8: An access at 0x3FC covers all eight pins at once, for both reading and writing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr and state |
| pad_in | input | 8 | Asynchronous pad input levels |
| pad_oe | output | 8 | Per-pin output enable (direction register) |
| pad_out | output | 8 | Per-pin output level (output latch) |

## Verification
Register effects of a write are due one edge after the strobe. The bench raises the strobe at a falling edge, lets exactly one rising edge pass, and samples pad_oe and pad_out at the following falling edge. Reads are combinational: the bench sets the address at a falling edge and samples bus_rdata 1 ns later, so no edge falls between setting the address and sampling the result. The synchroniser result is due on the second rising edge after pad_in changes. The bench samples once after the first edge, where it expects the old level, and once after the second, where it expects the new one.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  // Which register an address selects
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_DIR  = 2'd2
  } port_sel_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= '0;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_port_pkg::*;
#(
  parameter int              NPINS   = 8,
  parameter int              AW      = 12,
  parameter logic [AW-1:0]   DIR_OFS = 12'h400
) (
  input  logic [AW-1:0]    addr,
  output port_sel_e        sel,
  output logic [NPINS-1:0] lanes
);
  localparam int LANE_LO = 2;
  localparam int LANE_HI = NPINS + LANE_LO - 1;

  function automatic logic in_window(input logic [AW-1:0] a);
    return (a[AW-1:LANE_HI+1] == '0) && (a[LANE_LO-1:0] == '0);
  endfunction

  always_comb begin
    if (in_window(addr))      sel = SEL_DATA;
    else if (addr == DIR_OFS) sel = SEL_DIR;
    else                      sel = SEL_NONE;
  end

  assign lanes = addr[LANE_HI:LANE_LO];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dir_wr,
  input  logic             data_wr,
  input  logic [NPINS-1:0] lanes,
  input  logic [NPINS-1:0] wdata,
  output logic [NPINS-1:0] dir_q,
  output logic [NPINS-1:0] out_q
);
  // Only lanes that are selected and driven may change
  function automatic logic [NPINS-1:0] live_lanes(
    input logic [NPINS-1:0] sel_lanes, input logic [NPINS-1:0] dir);
    return sel_lanes & dir;
  endfunction

  function automatic logic [NPINS-1:0] merge_lanes(
    input logic [NPINS-1:0] old_v, input logic [NPINS-1:0] new_v,
    input logic [NPINS-1:0] m);
    return (old_v & ~m) | (new_v & m);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_wr) dir_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       out_q <= '0;
    else if (data_wr) out_q <= merge_lanes(out_q, wdata, live_lanes(lanes, dir_q));
  end
endmodule

// File: rtl/gpio_window_port.sv
module gpio_window_port
  import gpio_port_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int AW          = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_we,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out
);
  port_sel_e        sel;
  logic [NPINS-1:0] lanes;
  logic [NPINS-1:0] dir_q, out_q, pin_sync;

  // Named events for the checker
  logic is_data_hit, is_dir_hit, data_wr_ev, dir_wr_ev;
  logic [NPINS-1:0] pin_view;

  gpio_addr_decode #(.NPINS(NPINS), .AW(AW)) u_dec (
    .addr(bus_addr), .sel(sel), .lanes(lanes)
  );

  assign is_data_hit = (sel == SEL_DATA);
  assign is_dir_hit  = (sel == SEL_DIR);
  assign data_wr_ev  = bus_we && is_data_hit;
  assign dir_wr_ev   = bus_we && is_dir_hit;

  gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
  );

  gpio_port_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr_ev), .data_wr(data_wr_ev),
    .lanes(lanes), .wdata(bus_wdata), .dir_q(dir_q), .out_q(out_q)
  );

  // Outputs read back their driven level, inputs their synchronised level
  assign pin_view = (dir_q & out_q) | (~dir_q & pin_sync);

  always_comb begin
    unique case (sel)
      SEL_DATA: bus_rdata = pin_view & lanes;
      SEL_DIR:  bus_rdata = dir_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign pad_oe  = dir_q;
  assign pad_out = out_q;
endmodule

// File: rtl/gpio_window_port_chk.sv
module gpio_window_port_chk #(
  parameter int NPINS = 8,
  parameter int AW    = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    bus_addr,
  input logic             bus_we,
  input logic [NPINS-1:0] bus_wdata,
  input logic [NPINS-1:0] bus_rdata,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_out,
  input logic             is_data_hit,
  input logic             is_dir_hit
);
  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_dir_hit) |=> (pad_oe == $past(bus_wdata)));

  // R3
  lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_data_hit) |=>
      (((pad_out ^ $past(pad_out)) & ~($past(bus_addr[NPINS+1:2]) & $past(pad_oe))) == '0));

  // R4
  input_pin_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && is_data_hit) |=> (((pad_out ^ $past(pad_out)) & ~$past(pad_oe)) == '0));

  // R5
  masked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_data_hit |-> ((bus_rdata & ~bus_addr[NPINS+1:2]) == '0));

  // R7
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_data_hit && !is_dir_hit) |-> (bus_rdata == '0));

  // R7
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(bus_we && (is_data_hit || is_dir_hit))) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind gpio_window_port gpio_window_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_oe(pad_oe),
  .pad_out(pad_out), .is_data_hit(is_data_hit), .is_dir_hit(is_dir_hit)
);

// File: tb/gpio_window_port_test.sv
`timescale 1ns/1ps
module gpio_window_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in = '0;
  logic [7:0]  pad_oe, pad_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_window_port uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  // addr, wdata, expected pad_oe, expected pad_out after the write
  typedef struct packed {
    logic [11:0] addr;
    logic [7:0]  wdata;
    logic [7:0]  exp_oe;
    logic [7:0]  exp_out;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{12'h400, 8'h0F, 8'h0F, 8'h00},  // R2 low nibble outputs
    '{12'h3FC, 8'hFF, 8'h0F, 8'h0F},  // R8 all lanes, only outputs move
    '{12'h004, 8'h00, 8'h0F, 8'h0E},  // R3 pin 0 alone
    '{12'h020, 8'h00, 8'h0F, 8'h06},  // R3 pin 3 alone
    '{12'h040, 8'hFF, 8'h0F, 8'h06},  // R4 pin 4 is input
    '{12'h018, 8'h02, 8'h0F, 8'h02},  // R3 pins 1 and 2
    '{12'h800, 8'hFF, 8'h0F, 8'h02},  // R7 unmapped
    '{12'h3FD, 8'hFF, 8'h0F, 8'h02},  // R7 unaligned
    '{12'h400, 8'hFF, 8'hFF, 8'h02},  // R4 switch keeps old latch
    '{12'h3FC, 8'hA5, 8'hFF, 8'hA5}   // R8 full write
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    repeat (3) @(posedge clk);
    // R1 reset state
    check("R1 oe", pad_oe, 8'h00);
    check("R1 out", pad_out, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    do_read(12'h400, rd);
    check("R1 dir read", rd, 8'h00);

    for (int i = 0; i < 10; i++) begin
      do_write(VECS[i].addr, VECS[i].wdata);
      check($sformatf("R2/R3 row %0d oe", i), pad_oe, VECS[i].exp_oe);
      check($sformatf("R3/R4/R7 row %0d out", i), pad_out, VECS[i].exp_out);
    end

    // R5 mixed read: outputs low nibble, inputs high nibble
    do_write(12'h400, 8'h0F);
    @(negedge clk) pad_in = 8'h3C;
    repeat (3) @(posedge clk);
    do_read(12'h3FC, rd);
    check("R5 full read", rd, 8'h35);
    do_read(12'h0C0, rd);
    check("R5 lanes 4,5", rd, 8'h30);
    do_read(12'h004, rd);
    check("R5 pin0", rd, 8'h01);
    do_read(12'h400, rd);
    check("R2 dir readback", rd, 8'h0F);
    do_read(12'h800, rd);
    check("R7 read 0x800", rd, 8'h00);
    do_read(12'h401, rd);
    check("R7 read 0x401", rd, 8'h00);

    // R7 write to 0x404 ignored
    do_write(12'h404, 8'h00);
    check("R7 oe after 0x404", pad_oe, 8'h0F);

    // R6 two-edge synchroniser latency
    @(negedge clk);
    bus_addr = 12'h3FC;
    pad_in = 8'hC3;
    @(posedge clk);
    @(negedge clk);
    check("R6 after one edge", bus_rdata, 8'h35);
    @(posedge clk);
    @(negedge clk);
    check("R6 after two edges", bus_rdata, 8'hC5);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule